// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the 32-bit memory-mapped front end of an interrupt controller. A simple request port carries a valid strobe, a write flag, a byte offset and write data. For each request the block decodes the offset into one of its register groups. It holds the domain interrupt-enable flag, the per-source configuration and target words and the software message word. It turns writes to the set and clear bit vectors, and to the number registers, into single-cycle set and clear pulses for the gateway and dispatcher logic. That logic owns the pending, enable and rectified-input state, which flows back into the block as input vectors so that reads can return it.

Read data and the error flag are combinational and valid while the request is presented. Writes take effect at the next rising edge: the stored registers update on that edge, and the pulse vectors are high for exactly the one cycle that follows. Sources are numbered 1 to `NSRC`, and source 0 does not exist. Each bit vector spans `ceil((NSRC+1)/32)` words.

Top module: `irq_regfront`

## Requirements
- R1: A request whose offset has either of its two low bits set raises `rsp_err` while it is presented, returns read data 0, and changes no register and produces no pulse.
- R2: At offset 0x0000, a write stores only data bit 8 as the domain interrupt-enable (`ie_o`). A read returns 0x80000004 OR (enable << 8).
- R3: Configuration entries at 0x0004 + 4k and target entries at 0x3004 + 4k (k = 0 .. NSRC-1) belong to source k+1. They store the full written word, read it back, and drive slice k of `cfg_o` and `tgt_o` respectively.
- R4: A write to word w of the set-pending (0x1C00), clear-pending (0x1D00), set-enable (0x1E00) or clear-enable (0x1F00) vectors pulses the matching output for every source s = 32w + b whose data bit b is 1. Zero bits, source 0 and numbers above NSRC produce nothing.
- R5: Reading word w returns, for source 32w + b in bit b, `pend_i` from the set-pending vector, `rin_i` from the clear-pending vector and `en_i` from the set-enable vector. The clear-enable vector reads 0. Bits that map to no source read 0.
- R6: Writing a source number n to 0x1CDC, 0x2000 (set pending), 0x1DDC (clear pending), 0x1EDC (set enable) or 0x1FDC (clear enable) pulses source n when 1 <= n <= NSRC, and does nothing otherwise. All number registers read 0.
- R7: A write to 0x2004 byte-swaps the data (bits 7:0 become 31:24, and so on) and then acts as a set-pending number write.
- R8: A write to 0x3000 stores the word on `msg_o`, reads back, and raises `msg_fire_o` for exactly the following cycle.
- R9: An aligned offset that matches no register reads 0, raises no error, and has no effect when written.
- R10: After reset, `ie_o`, `cfg_o`, `tgt_o`, `msg_o` and all pulse outputs are 0. Reads never produce a pulse, and every pulse lasts one cycle.
- R11: Each bit vector spans exactly ceil((NSRC+1)/32) words, and the word just past the last one is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, combinational |
| rsp_err | output | 1 | Misaligned offset flag |
| pend_i | input | NSRC | Pending state of sources NSRC..1 |
| en_i | input | NSRC | Enable state of sources NSRC..1 |
| rin_i | input | NSRC | Rectified input of sources NSRC..1 |
| ie_o | output | 1 | Domain interrupt-enable |
| set_pend_o | output | NSRC | Set-pending pulses |
| clr_pend_o | output | NSRC | Clear-pending pulses |
| set_en_o | output | NSRC | Set-enable pulses |
| clr_en_o | output | NSRC | Clear-enable pulses |
| cfg_o | output | 32*NSRC | Configuration words, slice k for source k+1 |
| tgt_o | output | 32*NSRC | Target words, slice k for source k+1 |
| msg_fire_o | output | 1 | Software message strobe |
| msg_o | output | 32 | Software message word |

## Verification
The bound checker watches rules that hold on every cycle. A misaligned write or any read leaves every pulse low and the enable flag unchanged. Pulses and the message strobe only follow a write. The enable flag changes only after a domain write. The fixed domain bits, the number registers and the clear-enable words always read as their constant values. Only the bench's sweeps can show the mapping arithmetic: which source each word bit reaches, the source k+1 indexing of the arrays, the byte swap of the big-endian alias, the word count, and whether stored values read back.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

  typedef enum logic [3:0] {
    RK_NONE, RK_DOM, RK_CFG, RK_TGT,
    RK_SIP_W, RK_CIP_W, RK_SIE_W, RK_CIE_W,
    RK_SIP_N, RK_CIP_N, RK_SIE_N, RK_CIE_N,
    RK_SIP_LE, RK_SIP_BE, RK_MSG
  } reg_kind_e;

  localparam int unsigned OFF_DOM    = 32'h0000;
  localparam int unsigned OFF_CFG    = 32'h0004;
  localparam int unsigned OFF_SIP_W  = 32'h1C00;
  localparam int unsigned OFF_SIP_N  = 32'h1CDC;
  localparam int unsigned OFF_CIP_W  = 32'h1D00;
  localparam int unsigned OFF_CIP_N  = 32'h1DDC;
  localparam int unsigned OFF_SIE_W  = 32'h1E00;
  localparam int unsigned OFF_SIE_N  = 32'h1EDC;
  localparam int unsigned OFF_CIE_W  = 32'h1F00;
  localparam int unsigned OFF_CIE_N  = 32'h1FDC;
  localparam int unsigned OFF_SIP_LE = 32'h2000;
  localparam int unsigned OFF_SIP_BE = 32'h2004;
  localparam int unsigned OFF_MSG    = 32'h3000;
  localparam int unsigned OFF_TGT    = 32'h3004;

  localparam logic [31:0] DOM_FIXED  = 32'h8000_0004;
  localparam int unsigned DOM_IE_BIT = 8;

  function automatic logic [31:0] swap_bytes(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/irqfe_rst_sync.sv
module irqfe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irqfe_decode.sv
module irqfe_decode
  import irqfe_pkg::*;
#(
  parameter int unsigned NSRC = 40,
  parameter int unsigned AW   = 16
) (
  input  logic [AW-1:0] addr,
  output reg_kind_e     kind,
  output logic [AW-3:0] idx,
  output logic          misal
);
  localparam int unsigned IW     = AW - 2;
  localparam int unsigned NWORDS = (NSRC + 1 + 31) / 32;

  logic [IW-1:0] wa;
  assign wa    = addr[AW-1:2];
  assign misal = |addr[1:0];

  // word-address window test: base is a byte offset, n a count of words
  function automatic logic in_win(input logic [IW-1:0] a,
                                  input int unsigned base,
                                  input int unsigned n);
    return (a >= IW'(base / 4)) && (a < IW'(base / 4 + n));
  endfunction

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    if (!misal) begin
      if (wa == IW'(OFF_DOM / 4)) begin
        kind = RK_DOM;
      end else if (in_win(wa, OFF_CFG, NSRC)) begin
        kind = RK_CFG;
        idx  = wa - IW'(OFF_CFG / 4);
      end else if (in_win(wa, OFF_SIP_W, NWORDS)) begin
        kind = RK_SIP_W;
        idx  = wa - IW'(OFF_SIP_W / 4);
      end else if (wa == IW'(OFF_SIP_N / 4)) begin
        kind = RK_SIP_N;
      end else if (in_win(wa, OFF_CIP_W, NWORDS)) begin
        kind = RK_CIP_W;
        idx  = wa - IW'(OFF_CIP_W / 4);
      end else if (wa == IW'(OFF_CIP_N / 4)) begin
        kind = RK_CIP_N;
      end else if (in_win(wa, OFF_SIE_W, NWORDS)) begin
        kind = RK_SIE_W;
        idx  = wa - IW'(OFF_SIE_W / 4);
      end else if (wa == IW'(OFF_SIE_N / 4)) begin
        kind = RK_SIE_N;
      end else if (in_win(wa, OFF_CIE_W, NWORDS)) begin
        kind = RK_CIE_W;
        idx  = wa - IW'(OFF_CIE_W / 4);
      end else if (wa == IW'(OFF_CIE_N / 4)) begin
        kind = RK_CIE_N;
      end else if (wa == IW'(OFF_SIP_LE / 4)) begin
        kind = RK_SIP_LE;
      end else if (wa == IW'(OFF_SIP_BE / 4)) begin
        kind = RK_SIP_BE;
      end else if (wa == IW'(OFF_MSG / 4)) begin
        kind = RK_MSG;
      end else if (in_win(wa, OFF_TGT, NSRC)) begin
        kind = RK_TGT;
        idx  = wa - IW'(OFF_TGT / 4);
      end
    end
  end
endmodule

// File: rtl/irqfe_pulse.sv
module irqfe_pulse
  import irqfe_pkg::*;
#(
  parameter int unsigned NSRC = 40,
  parameter int unsigned AW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_kind_e     kind,
  input  logic [AW-3:0] idx,
  input  logic [31:0]   wdata,
  output logic [NSRC:1] set_pend_o,
  output logic [NSRC:1] clr_pend_o,
  output logic [NSRC:1] set_en_o,
  output logic [NSRC:1] clr_en_o
);
  localparam int unsigned IW = AW - 2;

  logic [31:0]   num_be;
  logic [NSRC:1] sp_d, cp_d, se_d, ce_d;
  logic [NSRC:1] sp_q, cp_q, se_q, ce_q;

  assign num_be = swap_bytes(wdata);

  // next-state: one small selector per source
  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    localparam int unsigned WI = s / 32;
    localparam int unsigned BI = s % 32;
    logic wsel, nsel, bsel;
    assign wsel = (idx == IW'(WI)) && wdata[BI];
    assign nsel = (wdata == 32'(s));
    assign bsel = (num_be == 32'(s));
    assign sp_d[s] = wr_en && (((kind == RK_SIP_W) && wsel) ||
                               (((kind == RK_SIP_N) || (kind == RK_SIP_LE)) && nsel) ||
                               ((kind == RK_SIP_BE) && bsel));
    assign cp_d[s] = wr_en && (((kind == RK_CIP_W) && wsel) ||
                               ((kind == RK_CIP_N) && nsel));
    assign se_d[s] = wr_en && (((kind == RK_SIE_W) && wsel) ||
                               ((kind == RK_SIE_N) && nsel));
    assign ce_d[s] = wr_en && (((kind == RK_CIE_W) && wsel) ||
                               ((kind == RK_CIE_N) && nsel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      cp_q <= '0;
      se_q <= '0;
      ce_q <= '0;
    end else begin
      sp_q <= sp_d;
      cp_q <= cp_d;
      se_q <= se_d;
      ce_q <= ce_d;
    end
  end

  assign set_pend_o = sp_q;
  assign clr_pend_o = cp_q;
  assign set_en_o   = se_q;
  assign clr_en_o   = ce_q;
endmodule

// File: rtl/irqfe_store.sv
module irqfe_store
  import irqfe_pkg::*;
#(
  parameter int unsigned NSRC = 40,
  parameter int unsigned AW   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_kind_e        kind,
  input  logic [AW-3:0]    idx,
  input  logic [31:0]      wdata,
  output logic             ie_o,
  output logic [NSRC*32-1:0] cfg_o,
  output logic [NSRC*32-1:0] tgt_o,
  output logic [31:0]      msg_o,
  output logic             msg_fire_o
);
  localparam int unsigned IW = AW - 2;

  logic        ie_we, ie_d, ie_q;
  logic        msg_we, fire_q;
  logic [31:0] msg_q;

  assign ie_we  = wr_en && (kind == RK_DOM);
  assign ie_d   = wdata[DOM_IE_BIT];
  assign msg_we = wr_en && (kind == RK_MSG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= 1'b0;
    else if (ie_we) ie_q <= ie_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      msg_q <= '0;
    else if (msg_we) msg_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= msg_we;
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_ent
    logic        cfg_we, tgt_we;
    logic [31:0] cfg_r, tgt_r;
    assign cfg_we = wr_en && (kind == RK_CFG) && (idx == IW'(k));
    assign tgt_we = wr_en && (kind == RK_TGT) && (idx == IW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_r <= '0;
      else if (cfg_we) cfg_r <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tgt_r <= '0;
      else if (tgt_we) tgt_r <= wdata;
    end

    assign cfg_o[k*32 +: 32] = cfg_r;
    assign tgt_o[k*32 +: 32] = tgt_r;
  end

  assign ie_o       = ie_q;
  assign msg_o      = msg_q;
  assign msg_fire_o = fire_q;
endmodule

// File: rtl/irq_regfront.sv
module irq_regfront
  import irqfe_pkg::*;
#(
  parameter int unsigned NSRC = 40,
  parameter int unsigned AW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [AW-1:0]      req_addr,
  input  logic [31:0]        req_wdata,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  input  logic [NSRC:1]      pend_i,
  input  logic [NSRC:1]      en_i,
  input  logic [NSRC:1]      rin_i,
  output logic               ie_o,
  output logic [NSRC:1]      set_pend_o,
  output logic [NSRC:1]      clr_pend_o,
  output logic [NSRC:1]      set_en_o,
  output logic [NSRC:1]      clr_en_o,
  output logic [NSRC*32-1:0] cfg_o,
  output logic [NSRC*32-1:0] tgt_o,
  output logic               msg_fire_o,
  output logic [31:0]        msg_o
);
  localparam int unsigned IW     = AW - 2;
  localparam int unsigned NWORDS = (NSRC + 1 + 31) / 32;
  localparam int unsigned PADW   = NWORDS * 32;

  logic          rst_sync_n;
  reg_kind_e     kind;
  logic [IW-1:0] idx;
  logic          misal;
  logic          wr_en;
  logic [31:0]   rd_word;
  logic [PADW-1:0] pend_pad, en_pad, rin_pad;

  irqfe_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  irqfe_decode #(.NSRC(NSRC), .AW(AW)) u_dec (
    .addr (req_addr),
    .kind (kind),
    .idx  (idx),
    .misal(misal)
  );

  assign wr_en = req_valid && req_write && !misal;

  irqfe_pulse #(.NSRC(NSRC), .AW(AW)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .kind      (kind),
    .idx       (idx),
    .wdata     (req_wdata),
    .set_pend_o(set_pend_o),
    .clr_pend_o(clr_pend_o),
    .set_en_o  (set_en_o),
    .clr_en_o  (clr_en_o)
  );

  irqfe_store #(.NSRC(NSRC), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .kind      (kind),
    .idx       (idx),
    .wdata     (req_wdata),
    .ie_o      (ie_o),
    .cfg_o     (cfg_o),
    .tgt_o     (tgt_o),
    .msg_o     (msg_o),
    .msg_fire_o(msg_fire_o)
  );

  // state vectors placed at their source number; bit 0 and tail stay zero
  always_comb begin
    pend_pad         = '0;
    en_pad           = '0;
    rin_pad          = '0;
    pend_pad[NSRC:1] = pend_i;
    en_pad[NSRC:1]   = en_i;
    rin_pad[NSRC:1]  = rin_i;
  end

  always_comb begin
    rd_word = '0;
    unique case (kind)
      RK_DOM: rd_word = DOM_FIXED | {23'd0, ie_o, 8'd0};
      RK_CFG: for (int k = 0; k < NSRC; k++)
                if (idx == IW'(k)) rd_word = cfg_o[k*32 +: 32];
      RK_TGT: for (int k = 0; k < NSRC; k++)
                if (idx == IW'(k)) rd_word = tgt_o[k*32 +: 32];
      RK_SIP_W: for (int w = 0; w < NWORDS; w++)
                  if (idx == IW'(w)) rd_word = pend_pad[w*32 +: 32];
      RK_CIP_W: for (int w = 0; w < NWORDS; w++)
                  if (idx == IW'(w)) rd_word = rin_pad[w*32 +: 32];
      RK_SIE_W: for (int w = 0; w < NWORDS; w++)
                  if (idx == IW'(w)) rd_word = en_pad[w*32 +: 32];
      RK_MSG:  rd_word = msg_o;
      default: rd_word = '0;
    endcase
  end

  assign rsp_rdata = (req_valid && !req_write) ? rd_word : 32'd0;
  assign rsp_err   = req_valid && misal;
endmodule

// File: rtl/irq_regfront_chk.sv
module irq_regfront_chk #(
  parameter int unsigned NSRC = 40,
  parameter int unsigned AW   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [AW-1:0]      req_addr,
  input logic [31:0]        rsp_rdata,
  input logic               rsp_err,
  input logic               ie_o,
  input logic [NSRC:1]      set_pend_o,
  input logic [NSRC:1]      clr_pend_o,
  input logic [NSRC:1]      set_en_o,
  input logic [NSRC:1]      clr_en_o,
  input logic               msg_fire_o
);
  logic any_pulse, rd_req, wr_req, num_off, cie_off;

  assign any_pulse = (|set_pend_o) || (|clr_pend_o) || (|set_en_o) || (|clr_en_o);
  assign rd_req    = req_valid && !req_write;
  assign wr_req    = req_valid && req_write;
  assign num_off   = (req_addr == AW'(32'h1CDC)) || (req_addr == AW'(32'h1DDC)) ||
                     (req_addr == AW'(32'h1EDC)) || (req_addr == AW'(32'h1FDC)) ||
                     (req_addr == AW'(32'h2000)) || (req_addr == AW'(32'h2004));
  assign cie_off   = (req_addr == AW'(32'h1F00));

  a_r1_misaligned_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (req_addr[1:0] != 2'b00)) |=> (!any_pulse && !msg_fire_o && $stable(ie_o)));

  a_r1_aligned_no_error: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[1:0] == 2'b00)) |-> !rsp_err);

  a_r2_ie_only_by_domain_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ie_o) |-> $past(wr_req && (req_addr == AW'(0))));

  a_r2_domain_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && (req_addr == AW'(0))) |->
      (rsp_rdata[31] && rsp_rdata[2] && (rsp_rdata[8] == ie_o)));

  a_r4_pulse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> $past(wr_req));

  a_r5_clear_enable_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && cie_off) |-> (rsp_rdata == 32'd0));

  a_r6_number_regs_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && num_off) |-> (rsp_rdata == 32'd0));

  a_r8_fire_follows_msg_write: assert property (@(posedge clk) disable iff (!rst_n)
    msg_fire_o |-> $past(wr_req && (req_addr == AW'(32'h3000))));

  a_r10_read_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (!any_pulse && !msg_fire_o));
endmodule

bind irq_regfront irq_regfront_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .ie_o      (ie_o),
  .set_pend_o(set_pend_o),
  .clr_pend_o(clr_pend_o),
  .set_en_o  (set_en_o),
  .clr_en_o  (clr_en_o),
  .msg_fire_o(msg_fire_o)
);

// File: tb/tb_irq_regfront.sv
`timescale 1ns/1ps
module tb_irq_regfront;
  localparam int unsigned NSRC   = 40;
  localparam int unsigned AW     = 16;
  localparam int unsigned NWORDS = (NSRC + 1 + 31) / 32;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req_valid, req_write;
  logic [AW-1:0]      req_addr;
  logic [31:0]        req_wdata;
  logic [31:0]        rsp_rdata;
  logic               rsp_err;
  logic [NSRC:1]      pend_i, en_i, rin_i;
  logic               ie_o;
  logic [NSRC:1]      set_pend_o, clr_pend_o, set_en_o, clr_en_o;
  logic [NSRC*32-1:0] cfg_o, tgt_o;
  logic               msg_fire_o;
  logic [31:0]        msg_o;

  always #4 clk = ~clk;

  irq_regfront #(.NSRC(NSRC), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .pend_i(pend_i), .en_i(en_i), .rin_i(rin_i),
    .ie_o(ie_o), .set_pend_o(set_pend_o), .clr_pend_o(clr_pend_o),
    .set_en_o(set_en_o), .clr_en_o(clr_en_o), .cfg_o(cfg_o), .tgt_o(tgt_o),
    .msg_fire_o(msg_fire_o), .msg_o(msg_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [NSRC:1] pv [4];
  logic          w_err, w_fire;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1 w_err = rsp_err;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    #1;
    pv[0] = set_pend_o; pv[1] = clr_pend_o; pv[2] = set_en_o; pv[3] = clr_en_o;
    w_fire = msg_fire_o;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d,
                          output logic e);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 32'hDEAD_BEEF;
    #1 d = rsp_rdata; e = rsp_err;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    pv[0] = set_pend_o; pv[1] = clr_pend_o; pv[2] = set_en_o; pv[3] = clr_en_o;
    w_fire = msg_fire_o;
  endtask

  function automatic logic [NSRC:1] word_hits(input int w, input logic [31:0] d);
    logic [NSRC:1] r = '0;
    for (int s = 1; s <= NSRC; s++)
      if ((s / 32) == w && d[s % 32]) r[s] = 1'b1;
    return r;
  endfunction

  function automatic logic [NSRC:1] num_hit(input logic [31:0] n);
    logic [NSRC:1] r = '0;
    for (int s = 1; s <= NSRC; s++)
      if (n == 32'(s)) r[s] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] word_of(input logic [NSRC:1] v, input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int s = w * 32 + b;
      if (s >= 1 && s <= NSRC) r[b] = v[s];
    end
    return r;
  endfunction

  function automatic logic [31:0] cfg_pat(input int k);
    return 32'hC001_0000 ^ (32'(k) * 32'h0101_0101);
  endfunction

  function automatic logic [31:0] tgt_pat(input int k);
    return 32'h0ACE_0000 + (32'(k) * 32'h0003_0007);
  endfunction

  function automatic bit no_pulses();
    return (pv[0] == '0) && (pv[1] == '0) && (pv[2] == '0) && (pv[3] == '0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        re;
    logic [31:0] wbase [4];
    logic [31:0] nreg [4];
    logic [31:0] unm [5];
    logic [31:0] mis [6];
    wbase = '{32'h1C00, 32'h1D00, 32'h1E00, 32'h1F00};
    nreg  = '{32'h1CDC, 32'h1DDC, 32'h1EDC, 32'h1FDC};
    unm   = '{32'h1000, 32'h2008, 32'h0004 + 4 * NSRC, 32'h3004 + 4 * NSRC, 32'hFFFC};
    mis   = '{32'h0001, 32'h0002, 32'h0003, 32'h0005, 32'h1C01, 32'h3002};

    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    for (int s = 1; s <= NSRC; s++) begin
      pend_i[s] = (s % 3 == 0);
      en_i[s]   = (s % 5 != 1);
      rin_i[s]  = ((s * s) % 7) < 3;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(ie_o == 1'b0, "R10 reset ie", 64'(ie_o), 0);
    chk(cfg_o == '0 && tgt_o == '0, "R10 reset cfg/tgt", 64'(cfg_o[63:0]), 0);
    chk(msg_o == '0 && !msg_fire_o, "R10 reset msg", 64'(msg_o), 0);
    chk(set_pend_o == '0 && clr_pend_o == '0 && set_en_o == '0 && clr_en_o == '0,
        "R10 reset pulses", 64'(set_pend_o), 0);

    // R2 domain register
    bus_read(16'h0000, rd, re);
    chk(rd == 32'h8000_0004 && !re, "R2 domain read after reset", 64'(rd), 64'h80000004);
    bus_write(16'h0000, 32'hFFFF_FFFF);
    chk(ie_o == 1'b1, "R2 ie set", 64'(ie_o), 1);
    bus_read(16'h0000, rd, re);
    chk(rd == 32'h8000_0104, "R2 domain read ie=1", 64'(rd), 64'h80000104);
    bus_write(16'h0000, 32'hFFFF_FEFF);
    chk(ie_o == 1'b0, "R2 only bit 8 writable", 64'(ie_o), 0);
    bus_write(16'h0000, 32'h0000_0100);
    chk(ie_o == 1'b1 && no_pulses(), "R2 ie set by bit 8 alone", 64'(ie_o), 1);

    // R3 configuration and target arrays
    for (int k = 0; k < NSRC; k++) begin
      bus_write(AW'(32'h0004 + 4 * k), cfg_pat(k));
      bus_write(AW'(32'h3004 + 4 * k), tgt_pat(k));
    end
    for (int k = 0; k < NSRC; k++) begin
      bus_read(AW'(32'h0004 + 4 * k), rd, re);
      chk(rd == cfg_pat(k), "R3 cfg readback", 64'(rd), 64'(cfg_pat(k)));
      chk(cfg_o[k*32 +: 32] == cfg_pat(k), "R3 cfg_o slice for source k+1",
          64'(cfg_o[k*32 +: 32]), 64'(cfg_pat(k)));
      bus_read(AW'(32'h3004 + 4 * k), rd, re);
      chk(rd == tgt_pat(k), "R3 tgt readback", 64'(rd), 64'(tgt_pat(k)));
      chk(tgt_o[k*32 +: 32] == tgt_pat(k), "R3 tgt_o slice", 64'(tgt_o[k*32 +: 32]),
          64'(tgt_pat(k)));
    end

    // R4 word writes, two data patterns, every vector and word
    for (int a = 0; a < 4; a++) begin
      for (int w = 0; w < NWORDS; w++) begin
        for (int p = 0; p < 2; p++) begin
          logic [31:0] d;
          d = (p == 0) ? 32'hFFFF_FFFF : 32'hA5C3_5A3C;
          bus_write(AW'(wbase[a] + 4 * w), d);
          for (int o = 0; o < 4; o++) begin
            logic [NSRC:1] e;
            e = (o == a) ? word_hits(w, d) : '0;
            chk(pv[o] == e, "R4 word write pulses", 64'(pv[o]), 64'(e));
          end
          @(negedge clk); #1;
          chk(set_pend_o == '0 && clr_pend_o == '0 && set_en_o == '0 && clr_en_o == '0,
              "R10 pulse lasts one cycle", 64'(set_pend_o | clr_pend_o | set_en_o | clr_en_o), 0);
        end
      end
      // R11 word just past the last is unmapped
      bus_write(AW'(wbase[a] + 4 * NWORDS), 32'hFFFF_FFFF);
      chk(no_pulses() && !w_err, "R11 write past last word", 64'(pv[a]), 0);
      bus_read(AW'(wbase[a] + 4 * NWORDS), rd, re);
      chk(rd == 32'd0 && !re, "R11 read past last word", 64'(rd), 0);
    end

    // R5 reading the vectors
    for (int w = 0; w < NWORDS; w++) begin
      bus_read(AW'(32'h1C00 + 4 * w), rd, re);
      chk(rd == word_of(pend_i, w), "R5 pending word", 64'(rd), 64'(word_of(pend_i, w)));
      chk(no_pulses() && !w_fire, "R10 read makes no pulse", 64'(pv[0]), 0);
      bus_read(AW'(32'h1D00 + 4 * w), rd, re);
      chk(rd == word_of(rin_i, w), "R5 input word", 64'(rd), 64'(word_of(rin_i, w)));
      bus_read(AW'(32'h1E00 + 4 * w), rd, re);
      chk(rd == word_of(en_i, w), "R5 enable word", 64'(rd), 64'(word_of(en_i, w)));
      bus_read(AW'(32'h1F00 + 4 * w), rd, re);
      chk(rd == 32'd0, "R5 clear-enable word reads zero", 64'(rd), 0);
    end
    pend_i = ~pend_i;
    bus_read(16'h1C04, rd, re);
    chk(rd == word_of(pend_i, 1), "R5 pending word follows input", 64'(rd),
        64'(word_of(pend_i, 1)));

    // R6 number registers, plus the little-endian alias
    for (int n = 0; n <= NSRC + 2; n++) begin
      for (int a = 0; a < 4; a++) begin
        bus_write(AW'(nreg[a]), 32'(n));
        for (int o = 0; o < 4; o++) begin
          logic [NSRC:1] e;
          e = (o == a) ? num_hit(32'(n)) : '0;
          chk(pv[o] == e, "R6 number write", 64'(pv[o]), 64'(e));
        end
      end
      bus_write(16'h2000, 32'(n));
      chk(pv[0] == num_hit(32'(n)) && pv[1] == '0, "R6 little-endian number",
          64'(pv[0]), 64'(num_hit(32'(n))));
    end
    bus_write(16'h1CDC, 32'h0001_0001);
    chk(no_pulses(), "R6 large number ignored", 64'(pv[0]), 0);
    for (int a = 0; a < 4; a++) begin
      bus_read(AW'(nreg[a]), rd, re);
      chk(rd == 32'd0, "R6 number reg reads zero", 64'(rd), 0);
    end
    bus_read(16'h2000, rd, re);
    chk(rd == 32'd0, "R6 little-endian reads zero", 64'(rd), 0);

    // R7 big-endian alias
    for (int n = 0; n <= NSRC + 1; n++) begin
      logic [31:0] sw;
      sw = {8'(n), 8'd0, 8'd0, 8'd0};
      bus_write(16'h2004, sw);
      chk(pv[0] == num_hit(32'(n)) && pv[1] == '0 && pv[2] == '0 && pv[3] == '0,
          "R7 swapped number", 64'(pv[0]), 64'(num_hit(32'(n))));
    end
    bus_write(16'h2004, 32'h0000_0005);
    chk(no_pulses(), "R7 unswapped value ignored", 64'(pv[0]), 0);
    bus_read(16'h2004, rd, re);
    chk(rd == 32'd0, "R7 big-endian reads zero", 64'(rd), 0);

    // R8 software message
    bus_write(16'h3000, 32'h1234_5678);
    chk(w_fire && msg_o == 32'h1234_5678, "R8 message fire and value", 64'(msg_o),
        64'h12345678);
    @(negedge clk); #1;
    chk(!msg_fire_o, "R8 fire one cycle", 64'(msg_fire_o), 0);
    bus_read(16'h3000, rd, re);
    chk(rd == 32'h1234_5678 && !w_fire, "R8 message readback", 64'(rd), 64'h12345678);

    // R1 misaligned offsets
    bus_write(16'h0000, 32'h0);
    for (int i = 0; i < 6; i++) begin
      bus_write(AW'(mis[i]), 32'hFFFF_FFFF);
      chk(w_err, "R1 misaligned write error", 64'(w_err), 1);
      chk(no_pulses() && !w_fire && !ie_o, "R1 misaligned write no effect", 64'(ie_o), 0);
      bus_read(AW'(mis[i]), rd, re);
      chk(re && rd == 32'd0, "R1 misaligned read", 64'(rd), 0);
    end
    chk(cfg_o[31:0] == cfg_pat(0), "R1 cfg untouched", 64'(cfg_o[31:0]), 64'(cfg_pat(0)));

    // R9 unmapped aligned offsets
    for (int i = 0; i < 5; i++) begin
      bus_write(AW'(unm[i]), 32'hFFFF_FFFF);
      chk(!w_err && no_pulses() && !w_fire && !ie_o, "R9 unmapped write no effect",
          64'(w_err), 0);
      bus_read(AW'(unm[i]), rd, re);
      chk(!re && rd == 32'd0, "R9 unmapped read zero", 64'(rd), 0);
    end
    chk(cfg_o[(NSRC-1)*32 +: 32] == cfg_pat(NSRC-1) &&
        tgt_o[(NSRC-1)*32 +: 32] == tgt_pat(NSRC-1) && msg_o == 32'h1234_5678,
        "R9 stored registers untouched", 64'(tgt_o[(NSRC-1)*32 +: 32]),
        64'(tgt_pat(NSRC-1)));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule